// File: doc/BRIEF.md
# DMA Channel Enable and Structure-Select Register Bank

This block holds two per-channel bitmaps for a multi-channel DMA controller. The first is the channel-enable map. The second is the select map that tells each channel whether it uses its primary or its alternate control structure. Software reaches both maps over a simple memory-mapped register port made of an address, a write strobe, write data and read data. Software never writes a map directly. Each map has one address where a 1 in a data bit sets that bit, and a second address where a 1 clears it. A 0 in the data leaves the bit alone.

The transfer engines drive two per-channel pulse vectors into the bank. A completion pulse disables the channel whose cycle has ended. An auto-alternate pulse switches a channel to its alternate structure, as ping-pong and scatter-gather operation need. The two maps are the outputs of the block, and the rest of the controller reads them.

Top module: `chan_ctl_bank`

## Requirements
- R1: While reset is high, and on the clock edge that ends it, both maps read all zeros: every channel is disabled and uses its primary structure.
- R2: A write to offset 0x028 with data bit n at 1 sets enable bit n (channel n, bit 0 is channel 0) on the next clock edge. Bits written as 0 keep their value.
- R3: A write to offset 0x02C with data bit n at 1 clears enable bit n on the next clock edge. Bits written as 0 keep their value.
- R4: A 1 on `hw_done[n]` clears enable bit n on the next clock edge.
- R5: When a write to 0x028 sets bit n in the same cycle that `hw_done[n]` is 1, enable bit n ends up at 1.
- R6: A write to offset 0x030 with data bit n at 1 sets select bit n (1 means alternate) on the next clock edge. Bits written as 0 keep their value.
- R7: A write to offset 0x034 with data bit n at 1 clears select bit n (0 means primary) on the next clock edge. Bits written as 0 keep their value.
- R8: A 1 on `hw_alt[n]` sets select bit n on the next clock edge.
- R9: When a write to 0x034 clears bit n in the same cycle that `hw_alt[n]` is 1, select bit n ends up at 0.
- R10: `bus_rdata` follows `bus_addr` in the same cycle. Offset 0x028 returns the enable map, 0x030 returns the select map, and every other offset (0x02C and 0x034 included) returns zero.
- R11: A write to any offset other than the four above, and any cycle with `bus_we` low, changes neither map. Only the hardware pulses can change the maps in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data, one bit per channel |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_done | input | 32 | Per-channel cycle-complete pulses |
| hw_alt | input | 32 | Per-channel auto-alternate pulses |
| chan_enable | output | 32 | Enable map, 1 = channel enabled |
| chan_alt | output | 32 | Select map, 1 = alternate structure |

## Verification
Every write and every hardware pulse shows in `chan_enable` and `chan_alt` one clock edge after the cycle in which it is presented. `bus_rdata` is due in the same cycle as the address. The bench drives inputs on the falling edge. It keeps a behavioural per-bit model that it updates on each rising edge from the inputs it drove. At the next falling edge, before it drives anything new, it compares both maps and the read data against the model. A map change therefore gets checked exactly one edge after its stimulus, and the read data gets checked against the address that has been held since the previous falling edge.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;

    localparam int OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_EN_SET  = 12'h028;
    localparam logic [OFS_W-1:0] OFS_EN_CLR  = 12'h02C;
    localparam logic [OFS_W-1:0] OFS_ALT_SET = 12'h030;
    localparam logic [OFS_W-1:0] OFS_ALT_CLR = 12'h034;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_ALT_SET,
        SEL_ALT_CLR
    } reg_sel_e;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic alt_set;
        logic alt_clr;
    } wr_strobe_t;

    function automatic reg_sel_e map_offset(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_EN_SET:  return SEL_EN_SET;
            OFS_EN_CLR:  return SEL_EN_CLR;
            OFS_ALT_SET: return SEL_ALT_SET;
            OFS_ALT_CLR: return SEL_ALT_CLR;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ctl_addr_decode.sv
module ctl_addr_decode
    import chan_ctl_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    input  logic             we,
    output reg_sel_e         rsel,
    output wr_strobe_t       wstb
);

    always_comb begin
        rsel         = map_offset(addr);
        wstb         = '0;
        wstb.en_set  = we && (rsel == SEL_EN_SET);
        wstb.en_clr  = we && (rsel == SEL_EN_CLR);
        wstb.alt_set = we && (rsel == SEL_ALT_SET);
        wstb.alt_clr = we && (rsel == SEL_ALT_CLR);
    end

endmodule

// File: rtl/ctl_bitmap.sv
module ctl_bitmap #(
    parameter int WIDTH    = 32,
    parameter bit SET_WINS = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_next;

    generate
        if (SET_WINS) begin : g_set_first
            always_comb q_next = (q & ~clr_vec) | set_vec;
        end else begin : g_clr_first
            always_comb q_next = (q | set_vec) & ~clr_vec;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

endmodule

// File: rtl/chan_ctl_bank.sv
module chan_ctl_bank
    import chan_ctl_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic              bus_we,
    input  logic [NUM_CH-1:0] bus_wdata,
    output logic [NUM_CH-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] hw_done,
    input  logic [NUM_CH-1:0] hw_alt,
    output logic [NUM_CH-1:0] chan_enable,
    output logic [NUM_CH-1:0] chan_alt
);

    localparam logic [NUM_CH-1:0] NONE_MASK = '0;

    reg_sel_e   rsel;
    wr_strobe_t wstb;

    logic [NUM_CH-1:0] en_set_v, en_clr_v, alt_set_v, alt_clr_v;

    ctl_addr_decode u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .rsel (rsel),
        .wstb (wstb)
    );

    always_comb begin
        en_set_v  = wstb.en_set  ? bus_wdata : NONE_MASK;
        en_clr_v  = (wstb.en_clr ? bus_wdata : NONE_MASK) | hw_done;
        alt_set_v = (wstb.alt_set ? bus_wdata : NONE_MASK) | hw_alt;
        alt_clr_v = wstb.alt_clr ? bus_wdata : NONE_MASK;
    end

    // Enable map: a software set beats a completion pulse.
    ctl_bitmap #(.WIDTH(NUM_CH), .SET_WINS(1'b1)) u_en (
        .clk     (clk),
        .rst     (rst),
        .set_vec (en_set_v),
        .clr_vec (en_clr_v),
        .q       (chan_enable)
    );

    // Select map: a software clear beats an auto-alternate pulse.
    ctl_bitmap #(.WIDTH(NUM_CH), .SET_WINS(1'b0)) u_alt (
        .clk     (clk),
        .rst     (rst),
        .set_vec (alt_set_v),
        .clr_vec (alt_clr_v),
        .q       (chan_alt)
    );

    always_comb begin
        case (rsel)
            SEL_EN_SET:  bus_rdata = chan_enable;
            SEL_ALT_SET: bus_rdata = chan_alt;
            default:     bus_rdata = NONE_MASK;
        endcase
    end

    assert_en_set_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_EN_SET) |=>
            ((chan_enable & $past(bus_wdata)) == $past(bus_wdata)));

    assert_done_clears_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFS_EN_SET) |=>
            ((chan_enable & $past(hw_done)) == NONE_MASK));

    assert_hw_alt_sets_R8: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFS_ALT_CLR) |=>
            ((chan_alt & $past(hw_alt)) == $past(hw_alt)));

    assert_clr_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_ALT_CLR) |=>
            ((chan_alt & $past(bus_wdata)) == NONE_MASK));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && hw_done == NONE_MASK && hw_alt == NONE_MASK) |=>
            ($stable(chan_enable) && $stable(chan_alt)));

    always_comb begin
        if (!rst && (bus_addr == OFS_EN_CLR || bus_addr == OFS_ALT_CLR))
            assert_clr_reads_zero_R10: assert (bus_rdata == NONE_MASK);
    end

endmodule

// File: tb/sim_chan_ctl_bank.sv
module sim_chan_ctl_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] hw_done = '0;
    logic [31:0] hw_alt = '0;
    logic [31:0] chan_enable;
    logic [31:0] chan_alt;

    always #2 clk = ~clk;

    chan_ctl_bank u0 (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .hw_done     (hw_done),
        .hw_alt      (hw_alt),
        .chan_enable (chan_enable),
        .chan_alt    (chan_alt)
    );

    int    n_run  = 0;
    int    n_fail = 0;
    bit    done_flag = 0;
    string tag = "R1";

    // Behavioural reference model, one bit at a time.
    logic [31:0] m_en, m_alt;

    always @(posedge clk) begin
        if (rst) begin
            m_en  <= '0;
            m_alt <= '0;
        end else begin
            for (int n = 0; n < 32; n++) begin
                if (bus_we && bus_addr == 12'h028 && bus_wdata[n])
                    m_en[n] <= 1'b1;
                else if ((bus_we && bus_addr == 12'h02C && bus_wdata[n]) || hw_done[n])
                    m_en[n] <= 1'b0;
                if (bus_we && bus_addr == 12'h034 && bus_wdata[n])
                    m_alt[n] <= 1'b0;
                else if ((bus_we && bus_addr == 12'h030 && bus_wdata[n]) || hw_alt[n])
                    m_alt[n] <= 1'b1;
            end
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [11:0] a);
        if (a == 12'h028) return m_en;
        if (a == 12'h030) return m_alt;
        return 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_now();
        check({tag, " enable map"}, chan_enable, m_en);
        check({tag, " select map"}, chan_alt, m_alt);
        check("R10 read data", bus_rdata, exp_rdata(bus_addr));
    endtask

    task automatic step(input logic [11:0] a, input logic we, input logic [31:0] wd,
                        input logic [31:0] dn, input logic [31:0] al);
        @(negedge clk);
        compare_now();
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = wd;
        hw_done   = dn;
        hw_alt    = al;
    endtask

    task automatic idle();
        step(12'h028, 1'b0, '0, '0, '0);
    endtask

    initial begin
        #400000;
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        repeat (3) idle();
        @(negedge clk);
        check("R1 enable after reset", chan_enable, 32'h0);
        check("R1 select after reset", chan_alt, 32'h0);
        rst = 1'b0;
        idle();

        tag = "R2";
        step(12'h028, 1'b1, 32'h0000_00F1, '0, '0);
        step(12'h028, 1'b1, 32'h8000_0000, '0, '0);
        step(12'h028, 1'b1, 32'h0000_0000, '0, '0);
        idle();
        check("R2 channel 0 and 31 set", chan_enable, 32'h8000_00F1);

        tag = "R3";
        step(12'h02C, 1'b1, 32'h0000_0011, '0, '0);
        step(12'h02C, 1'b1, 32'h0000_0000, '0, '0);
        idle();
        check("R3 clear of bits 0 and 4", chan_enable, 32'h8000_00E0);

        tag = "R4";
        step(12'h028, 1'b0, '0, 32'h8000_0020, '0);
        idle();
        check("R4 completion clears", chan_enable, 32'h0000_00C0);

        tag = "R5";
        step(12'h028, 1'b1, 32'h0000_0300, 32'h0000_0140, '0);
        idle();
        check("R5 set wins over completion", chan_enable, 32'h0000_0380);

        tag = "R6";
        step(12'h030, 1'b1, 32'h0000_F00F, '0, '0);
        step(12'h030, 1'b1, 32'h0000_0000, '0, '0);
        idle();
        check("R6 alternate set", chan_alt, 32'h0000_F00F);

        tag = "R7";
        step(12'h034, 1'b1, 32'h0000_000F, '0, '0);
        idle();
        check("R7 alternate clear", chan_alt, 32'h0000_F000);

        tag = "R8";
        step(12'h028, 1'b0, '0, '0, 32'h4000_0001);
        idle();
        check("R8 auto-alternate sets", chan_alt, 32'h4000_F001);

        tag = "R9";
        step(12'h034, 1'b1, 32'h4000_1000, '0, 32'h4000_1002);
        idle();
        check("R9 clear wins over auto-alternate", chan_alt, 32'h0000_E003);

        tag = "R10";
        step(12'h028, 1'b0, '0, '0, '0);
        step(12'h02C, 1'b0, '0, '0, '0);
        step(12'h030, 1'b0, '0, '0, '0);
        step(12'h034, 1'b0, '0, '0, '0);
        step(12'h038, 1'b0, '0, '0, '0);
        idle();

        tag = "R11";
        step(12'h024, 1'b1, 32'hFFFF_FFFF, '0, '0);
        step(12'h038, 1'b1, 32'hFFFF_FFFF, '0, '0);
        step(12'h000, 1'b1, 32'hFFFF_FFFF, '0, '0);
        step(12'h02A, 1'b1, 32'hFFFF_FFFF, '0, '0);
        step(12'h028, 1'b0, 32'hFFFF_FFFF, '0, '0);
        step(12'h02C, 1'b0, 32'hFFFF_FFFF, '0, '0);
        idle();
        check("R11 enable unchanged", chan_enable, 32'h0000_0380);
        check("R11 select unchanged", chan_alt, 32'h0000_E003);

        tag = "R2/R4/R8 mixed";
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            case ($urandom_range(0, 5))
                0: a = 12'h028;
                1: a = 12'h02C;
                2: a = 12'h030;
                3: a = 12'h034;
                4: a = 12'h040;
                default: a = 12'h02C;
            endcase
            step(a, 1'($urandom_range(0, 1)), $urandom,
                 $urandom & $urandom, $urandom & $urandom);
        end
        idle();

        tag = "R1 re-reset";
        rst = 1'b1;
        idle();
        idle();
        @(negedge clk);
        check("R1 maps cleared by reset", chan_enable | chan_alt, 32'h0);

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule